// File: doc/BRIEF.md
# Julia Constant Circle Sequencer

This block supplies the complex constant for a Julia-set animation. Each constant is a point on the unit circle. Every time the fractal engine finishes an image and raises a request, the block moves the angle forward by 5 degrees. It then computes the new point at run time and presents it with a valid flag. One full turn is 72 points, and after the last point the angle returns to zero.

The block does not store a cosine table. The angle is first reduced into the first quadrant. An iterative shift-and-add rotation (CORDIC) then runs one micro-rotation per clock. It starts from the gain-compensated constant on the real axis, and a small quadrant stage then fixes the signs and swaps the outputs for the other quadrants. The result uses the engine's signed 4.12 fixed-point format.

A full image takes hundreds of thousands of cycles, so the 16-cycle latency has no effect on the frame rate.

Top module: `julia_const_seq`

## Requirements
- R1: While reset is high, and after it is released, `c_valid` is 0, `angle_idx` is 0, and both `c_re` and `c_im` are 0 until the first request is accepted.
- R2: A request is accepted when `next_req` is high at a rising edge while no computation is running. An accepted request raises `angle_idx` by exactly one.
- R3: An accepted request at `angle_idx` = 71 sets `angle_idx` to 0, so the sequence has 72 points spaced 5 degrees apart.
- R4: When `c_valid` is high, `c_re` is the cosine of (5 degrees × `angle_idx`). It is written as a 16-bit two's complement number with 12 fraction bits, and is within 4 LSB of the exact value.
- R5: When `c_valid` is high, `c_im` is the sine of the same angle, in the same format and to the same 4 LSB accuracy. This holds in all four quadrants.
- R6: `c_valid` goes low at the edge that accepts a request. It goes high again, with the new constant, at the 16th rising edge counted from and including the accepting edge.
- R7: A request raised while a computation is running is ignored. `angle_idx` does not change, and the result is the one for the request already accepted.
- R8: While `c_valid` is high and no request arrives, `c_re`, `c_im` and `angle_idx` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| next_req | input | 1 | Asks for the next constant on the circle |
| c_re | output | 16 | Real part of the constant, signed 4.12 |
| c_im | output | 16 | Imaginary part of the constant, signed 4.12 |
| c_valid | output | 1 | Constant pair is current |
| angle_idx | output | 7 | Current angle step, 0 to 71 |

## Verification
The assertions check the index behaviour on every cycle: the index stays in range, steps by one on acceptance, wraps at 71, and does not move during a computation. They also check that valid stays low while the rotation runs and that the outputs hold while valid is high. They check that the iteration counter stays bounded.

The numerical accuracy can only be shown by the bench scenarios. The bench sweeps the whole revolution and compares all 72 points in all four quadrants against trigonometry computed in the bench. The same applies to the exact 16-edge latency and to the outcome of a request dropped in the middle of a computation.

// File: rtl/jc_pkg.sv
package jc_pkg;
    // Output format: signed 4.12
    localparam int DW      = 16;
    localparam int FRAC    = 12;
    // Internal datapath keeps extra guard bits
    localparam int GUARD   = 2;
    localparam int IW      = DW + GUARD;
    // Angle: radians with ZFRAC fraction bits
    localparam int ZFRAC   = 16;
    localparam int ZW      = 20;
    localparam int ITERS   = 14;
    localparam int CW      = $clog2(ITERS);
    localparam int STEPS   = 72;
    localparam int QSTEPS  = STEPS / 4;
    localparam int IDX_W   = $clog2(STEPS);
    // 5 degrees in radians, scaled by 2^ZFRAC
    localparam int STEP_RAD = 5719;
    // 1/K for 14 iterations, scaled by 2^(FRAC+GUARD)
    localparam int INV_GAIN = 9949;

    typedef logic signed [DW-1:0] dat_t;
    typedef logic signed [IW-1:0] int_t;
    typedef logic signed [ZW-1:0] ang_t;
    typedef logic [IDX_W-1:0]     idx_t;

    typedef struct packed {
        dat_t re;
        dat_t im;
    } pt_t;

    // arctan(2^-i) scaled by 2^ZFRAC
    function automatic ang_t atan_step(input logic [CW-1:0] i);
        case (i)
            4'd0:    return ang_t'(51472);
            4'd1:    return ang_t'(30386);
            4'd2:    return ang_t'(16055);
            4'd3:    return ang_t'(8150);
            4'd4:    return ang_t'(4091);
            4'd5:    return ang_t'(2047);
            default: return ang_t'(20'sd1 <<< (ZFRAC - int'(i)));
        endcase
    endfunction

    // Drop guard bits with round-half-up
    function automatic dat_t to_out(input int_t v);
        int_t t;
        t = v + int_t'(1 << (GUARD - 1));
        t = t >>> GUARD;
        return dat_t'(t);
    endfunction
endpackage

// File: rtl/jc_angle_step.sv
module jc_angle_step
    import jc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    output idx_t       idx,
    output idx_t       idx_nxt,
    output ang_t       phi_nxt,
    output logic [1:0] quad
);
    logic [IDX_W-1:0] rem_nxt;

    assign idx_nxt = (idx == idx_t'(STEPS - 1)) ? '0 : idx + idx_t'(1);
    assign rem_nxt = idx_t'(idx_nxt % idx_t'(QSTEPS));
    assign phi_nxt = ang_t'(rem_nxt) * ang_t'(STEP_RAD);
    assign quad    = 2'(idx / idx_t'(QSTEPS));

    always_ff @(posedge clk) begin
        if (rst)      idx <= '0;
        else if (adv) idx <= idx_nxt;
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx < idx_t'(STEPS)) else $error("index out of range"); // R3
endmodule

// File: rtl/jc_cordic_core.sv
module jc_cordic_core
    import jc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  ang_t phi,
    output logic done,
    output int_t xo,
    output int_t yo
);
    logic [CW-1:0] cnt;
    logic          run;
    ang_t          z;
    int_t          xs, ys;

    assign xs = xo >>> cnt;
    assign ys = yo >>> cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            xo   <= '0;
            yo   <= '0;
            z    <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                xo  <= int_t'(INV_GAIN);
                yo  <= '0;
                z   <= phi;
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                if (z >= 0) begin
                    xo <= xo - ys;
                    yo <= yo + xs;
                    z  <= z - atan_step(cnt);
                end else begin
                    xo <= xo + ys;
                    yo <= yo - xs;
                    z  <= z + atan_step(cnt);
                end
                if (cnt == CW'(ITERS - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CW'(ITERS))) else $error("iteration count overrun"); // R6
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> !run) else $error("done while still rotating"); // R6
endmodule

// File: rtl/jc_quad_fix.sv
module jc_quad_fix
    import jc_pkg::*;
(
    input  logic [1:0] quad,
    input  int_t       xi,
    input  int_t       yi,
    output pt_t        pt
);
    int_t re_i, im_i;

    always_comb begin
        unique case (quad)
            2'd0: begin re_i =  xi; im_i =  yi; end
            2'd1: begin re_i = -yi; im_i =  xi; end
            2'd2: begin re_i = -xi; im_i = -yi; end
            default: begin re_i =  yi; im_i = -xi; end
        endcase
        pt.re = to_out(re_i);
        pt.im = to_out(im_i);
    end
endmodule

// File: rtl/julia_const_seq.sv
module julia_const_seq
    import jc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             next_req,
    output logic [DW-1:0]    c_re,
    output logic [DW-1:0]    c_im,
    output logic             c_valid,
    output logic [IDX_W-1:0] angle_idx
);
    logic       busy, accept, done;
    idx_t       idx, idx_nxt;
    ang_t       phi_nxt;
    logic [1:0] quad;
    int_t       xr, yr;
    pt_t        pt_fix, pt_q;

    assign accept = next_req && !busy;

    jc_angle_step u_step (
        .clk(clk), .rst(rst), .adv(accept),
        .idx(idx), .idx_nxt(idx_nxt), .phi_nxt(phi_nxt), .quad(quad)
    );

    jc_cordic_core u_core (
        .clk(clk), .rst(rst), .start(accept), .phi(phi_nxt),
        .done(done), .xo(xr), .yo(yr)
    );

    jc_quad_fix u_fix (
        .quad(quad), .xi(xr), .yi(yr), .pt(pt_fix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            c_valid <= 1'b0;
            pt_q    <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            c_valid <= 1'b0;
        end else if (done) begin
            busy    <= 1'b0;
            c_valid <= 1'b1;
            pt_q    <= pt_fix;
        end
    end

    assign c_re      = pt_q.re;
    assign c_im      = pt_q.im;
    assign angle_idx = idx;

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (next_req && !busy && angle_idx != idx_t'(STEPS - 1)) |=> (angle_idx == $past(angle_idx) + idx_t'(1)))
        else $error("index did not step"); // R2
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (next_req && !busy && angle_idx == idx_t'(STEPS - 1)) |=> (angle_idx == '0))
        else $error("index did not wrap"); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(angle_idx)) else $error("index moved mid-computation"); // R7
    AST_VALID_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !c_valid) else $error("valid during computation"); // R6
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (c_valid && !next_req) |=> ($stable(c_re) && $stable(c_im) && c_valid))
        else $error("outputs changed while idle"); // R8
endmodule

// File: tb/sim_julia_const_seq.sv
module sim_julia_const_seq;
    localparam real PI = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        next_req = 1'b0;
    logic [15:0] c_re, c_im;
    logic        c_valid;
    logic [6:0]  angle_idx;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    julia_const_seq u0 (
        .clk(clk), .rst(rst), .next_req(next_req),
        .c_re(c_re), .c_im(c_im), .c_valid(c_valid), .angle_idx(angle_idx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic int exp_fix(input real v);
        real s;
        s = v * 4096.0;
        return (s >= 0.0) ? int'($floor(s + 0.5)) : -int'($floor(-s + 0.5));
    endfunction

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Issue one request; optionally inject an extra request mid-run.
    task automatic step_once(input int k, input bit inject);
        int n;
        int idx_mid;
        int exp_idx;
        int er, ei;
        real th;
        exp_idx = k % 72;
        @(negedge clk);
        next_req = 1'b1;
        n = 0;
        idx_mid = -1;
        while (n < 40) begin
            @(posedge clk);
            #1;
            next_req = 1'b0;
            n++;
            if (n == 1)
                chk(c_valid == 1'b0, "R6 valid low after accept", int'(c_valid), 0);
            if (inject && n == 5) begin
                next_req = 1'b1;
                idx_mid = int'(angle_idx);
            end
            if (c_valid) break;
        end
        chk(n == 16, "R6 latency", n, 16);
        chk(int'(angle_idx) == exp_idx, (exp_idx == 0) ? "R3 wrap index" : "R2 index step",
            int'(angle_idx), exp_idx);
        if (inject)
            chk(idx_mid == exp_idx, "R7 ignored request index", idx_mid, exp_idx);
        th = real'(exp_idx) * 5.0 * PI / 180.0;
        er = exp_fix($cos(th));
        ei = exp_fix($sin(th));
        chk(absdiff(int'($signed(c_re)), er) <= 4, "R4 cosine", int'($signed(c_re)), er);
        chk(absdiff(int'($signed(c_im)), ei) <= 4, "R5 sine", int'($signed(c_im)), ei);
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [15:0] hold_re, hold_im;
        repeat (3) @(posedge clk);
        #1;
        chk(c_valid == 1'b0, "R1 valid in reset", int'(c_valid), 0);
        chk(angle_idx == 7'd0, "R1 index in reset", int'(angle_idx), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(c_valid == 1'b0, "R1 valid after reset", int'(c_valid), 0);
        chk(angle_idx == 7'd0, "R1 index after reset", int'(angle_idx), 0);
        chk(c_re == 16'd0 && c_im == 16'd0, "R1 outputs zero", int'(c_re), 0);

        for (int k = 1; k <= 72; k++) begin
            step_once(k, (k == 5) || (k == 40));
            if (k == 20) begin
                hold_re = c_re;
                hold_im = c_im;
                repeat (6) @(negedge clk);
                chk(c_re == hold_re && c_im == hold_im && c_valid,
                    "R8 hold while idle", int'(c_re), int'(hold_re));
                chk(angle_idx == 7'd20, "R8 index hold", int'(angle_idx), 20);
            end
        end
        // One more step after the wrap
        step_once(73, 1'b0);
        finish_run();
    end
endmodule